// File: doc/BRIEF.md
# Serial-Load Register with Latched Parallel Outputs

This block collects a serial bit stream into an internal shift stage and presents it as a parallel word only after a separate store strobe copies it into an output latch. Shifting can therefore continue while the previously stored word stays on the outputs. The serial data line, the shift strobe, the store strobe, an active-low clear of the shift stage and an active-low output enable all come in asynchronously. They pass through synchronizers clocked by one system clock, and the two strobes are edge-detected in that domain. The last shift stage is brought out as a serial output, so several instances can be chained into a longer register.

The parallel outputs model tri-state driving as a data vector with a matching per-bit enable vector. Data moves only on strobe edges, so there is no valid/ready handshake and no back-pressure. The block accepts one bit per detected shift edge and one word per detected store edge. Both strobes must stay in each level for at least three system clocks. The data line must settle no later than the shift strobe's rising transition.

Top module: `serial_latch_reg`

## Requirements
- R1: A rising shift-strobe edge with clear inactive moves every shift-stage bit one position toward the top bit (WIDTH-1). The synchronized data bit enters bit 0.
- R2: A falling shift-strobe edge, or no edge at all, leaves the shift stage unchanged.
- R3: While the clear input is low, the shift stage is forced to all zeros. This overrides any shift edge in the same cycle.
- R4: A rising store-strobe edge copies the shift stage into the output latch. A falling store edge changes nothing.
- R5: Clears and shifts do not alter the output latch. It changes only on a rising store edge.
- R6: When shift and store edges are detected in the same system cycle, the latch receives the contents from before that shift.
- R7: With the output enable high, every bit of `par_en` is 0 and `par_data` reads 0. With it low, every bit of `par_en` is 1 and `par_data` shows the latch. Bit 0 of `par_data` is the first output stage.
- R8: `ser_out` equals the top shift-stage bit. When it feeds a second instance's `ser_in`, the two instances behave as one 2*WIDTH-bit register, and the first instance holds the most recently shifted bits.
- R9: After reset, the shift stage and the latch are zero, `ser_out` is 0 and the outputs are disabled.
- R10: An input transition made between clock edges takes effect on the shift stage or the latch at the third following clock edge. An output-enable change takes effect at the second following clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_in | input | 1 | Serial data in |
| shift_clk | input | 1 | Shift strobe; rising edge shifts |
| store_clk | input | 1 | Store strobe; rising edge latches |
| clr_n | input | 1 | Active-low shift-stage clear |
| oe_n | input | 1 | Active-low output enable |
| par_data | output | WIDTH | Latched parallel word, 0 when disabled |
| par_en | output | WIDTH | Per-bit drive enable, 1 = driven |
| ser_out | output | 1 | Top shift-stage bit for cascading |

## Verification
Two pairs of functions can fall in the same system cycle: a shift edge with a store edge, and a shift edge with an active clear. The bench raises the shift and store strobes at the same instant, so that both pass through the synchronizers together. It then checks that the latch holds the word from before the shift while the shift stage has still advanced, which a follow-up store reveals. For the clear case it raises the shift strobe with a data bit of 1 while clear is held low. A later store must show an all-zero word, and the latch must keep its earlier value through the clear.

// File: rtl/sipo_pkg.sv
package sipo_pkg;
  localparam int DEF_WIDTH = 8;
  localparam int DEF_SYNC  = 2;

  // bit positions inside the synchronized control vector
  localparam int CI_DATA  = 0;
  localparam int CI_SHIFT = 1;
  localparam int CI_STORE = 2;
  localparam int CI_CLRN  = 3;
  localparam int CI_OEN   = 4;
  localparam int CI_NUM   = 5;
endpackage

// File: rtl/sipo_sync.sv
module sipo_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] chain [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) chain[0] <= RST_VAL;
          else        chain[0] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) chain[s] <= RST_VAL;
          else        chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign sync_o = chain[STAGES-1];
endmodule

// File: rtl/sipo_edge.sv
module sipo_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  output logic rise_o
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~prev_q;

  AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o); // R1
endmodule

// File: rtl/sipo_shift_stage.sv
module sipo_shift_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step_i,
  input  logic         clr_i,
  input  logic         bit_i,
  output logic [W-1:0] sr_o
);
  logic [W-1:0] sr_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      sr_q <= '0;
    else if (clr_i)  sr_q <= '0;
    else if (step_i) sr_q <= {sr_q[W-2:0], bit_i};
  end

  assign sr_o = sr_q;

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (sr_o == '0)); // R3
  AST_SHIFT_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !clr_i) |=> (sr_o[W-1:1] == $past(sr_o[W-2:0]))); // R1
  AST_SHIFT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_i && !clr_i) |=> $stable(sr_o)); // R2
endmodule

// File: rtl/sipo_store_stage.sv
module sipo_store_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] word_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      q_q <= '0;
    else if (load_i) q_q <= word_i;
  end

  assign q_o = q_q;

  AST_STORE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (q_o == $past(word_i))); // R4
  AST_STORE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(q_o)); // R5
endmodule

// File: rtl/serial_latch_reg.sv
module serial_latch_reg #(
  parameter int WIDTH = sipo_pkg::DEF_WIDTH,
  parameter int SYNC_STAGES = sipo_pkg::DEF_SYNC
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ser_in,
  input  logic             shift_clk,
  input  logic             store_clk,
  input  logic             clr_n,
  input  logic             oe_n,
  output logic [WIDTH-1:0] par_data,
  output logic [WIDTH-1:0] par_en,
  output logic             ser_out
);
  import sipo_pkg::*;

  localparam logic [CI_NUM-1:0] CTRL_RST =
    (CI_NUM'(1) << CI_CLRN) | (CI_NUM'(1) << CI_OEN);

  logic [CI_NUM-1:0] raw_ctrl;
  logic [CI_NUM-1:0] syn_ctrl;
  logic [1:0]        strobe_lvl;
  logic [1:0]        strobe_rise;
  logic [WIDTH-1:0]  sr_w;
  logic [WIDTH-1:0]  latch_w;
  logic              drive_w;

  always_comb begin
    raw_ctrl           = '0;
    raw_ctrl[CI_DATA]  = ser_in;
    raw_ctrl[CI_SHIFT] = shift_clk;
    raw_ctrl[CI_STORE] = store_clk;
    raw_ctrl[CI_CLRN]  = clr_n;
    raw_ctrl[CI_OEN]   = oe_n;
  end

  sipo_sync #(.W(CI_NUM), .STAGES(SYNC_STAGES), .RST_VAL(CTRL_RST)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .async_i(raw_ctrl),
    .sync_o (syn_ctrl)
  );

  assign strobe_lvl = {syn_ctrl[CI_STORE], syn_ctrl[CI_SHIFT]};

  genvar e;
  generate
    for (e = 0; e < 2; e++) begin : g_edge
      sipo_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl_i (strobe_lvl[e]),
        .rise_o(strobe_rise[e])
      );
    end
  endgenerate

  sipo_shift_stage #(.W(WIDTH)) u_shift (
    .clk   (clk),
    .rst_n (rst_n),
    .step_i(strobe_rise[0]),
    .clr_i (~syn_ctrl[CI_CLRN]),
    .bit_i (syn_ctrl[CI_DATA]),
    .sr_o  (sr_w)
  );

  sipo_store_stage #(.W(WIDTH)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .load_i(strobe_rise[1]),
    .word_i(sr_w),
    .q_o   (latch_w)
  );

  assign drive_w  = ~syn_ctrl[CI_OEN];
  assign par_en   = {WIDTH{drive_w}};
  assign par_data = drive_w ? latch_w : '0;
  assign ser_out  = sr_w[WIDTH-1];

  AST_SAME_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_rise[0] && strobe_rise[1]) |=> (latch_w == $past(sr_w))); // R6
  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (par_en == '0) |-> (par_data == '0)); // R7
  AST_EN_UNIFORM: assert property (@(posedge clk) disable iff (!rst_n)
    (par_en == '0) || (par_en == '1)); // R7
  AST_CASCADE_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    $past(strobe_rise[0]) && !$past(syn_ctrl[CI_CLRN] == 1'b0)
      |-> (ser_out == $past(sr_w[WIDTH-2]))); // R8
endmodule

// File: tb/test_serial_latch_reg.sv
`timescale 1ns/1ps
module test_serial_latch_reg;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0, si = 1'b0, sclk = 1'b0, rclk = 1'b0, clr_n = 1'b1, oe_n = 1'b1;
  logic [7:0] d1, e1, d2, e2;
  logic so1, so2;
  logic [7:0] r1 = '0, r2 = '0, m1 = '0, m2 = '0, pre;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  serial_latch_reg i_serial_latch_reg (.clk(clk), .rst_n(rst_n), .ser_in(si),
    .shift_clk(sclk), .store_clk(rclk), .clr_n(clr_n), .oe_n(oe_n),
    .par_data(d1), .par_en(e1), .ser_out(so1));
  serial_latch_reg i_serial_latch_reg_b (.clk(clk), .rst_n(rst_n), .ser_in(so1),
    .shift_clk(sclk), .store_clk(rclk), .clr_n(clr_n), .oe_n(oe_n),
    .par_data(d2), .par_en(e2), .ser_out(so2));

  // pattern sent MSB first, expected word in first / second instance
  localparam logic [31:0] VEC [5] = '{
    {16'hA5C3, 8'hC3, 8'hA5}, {16'h0001, 8'h01, 8'h00},
    {16'hFFFF, 8'hFF, 8'hFF}, {16'h8000, 8'h00, 8'h80},
    {16'h3C96, 8'h96, 8'h3C}};

  task automatic cyc(input int n); repeat (n) @(negedge clk); endtask

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic shift_bit(input logic b);
    si = b; sclk = 1'b1; cyc(4);
    sclk = 1'b0; cyc(4);
    r2 = {r2[6:0], r1[7]}; r1 = {r1[6:0], b};
  endtask

  task automatic store_pulse;
    rclk = 1'b1; cyc(4); rclk = 1'b0; cyc(4);
    m1 = r1; m2 = r2;
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    cyc(3); rst_n = 1'b1; cyc(4);
    chk("R9 reset data", {8'h0, d1}, 16'h0);
    chk("R9 reset enable", {e1, e2}, 16'h0);
    chk("R9 reset ser_out", {15'h0, so1}, 16'h0);
    oe_n = 1'b0; cyc(4);

    // R10 store latency: 3 edges
    shift_bit(1); shift_bit(0); shift_bit(1);
    rclk = 1'b1; cyc(2);
    chk("R10 latch before third edge", {8'h0, d1}, 16'h0);
    cyc(1);
    chk("R10 latch at third edge", {8'h0, d1}, 16'h0005);
    rclk = 1'b0; cyc(4); m1 = r1; m2 = r2;

    // table walk: cascade R8, shift R1
    for (int p = 0; p < 5; p++) begin
      for (int b = 15; b >= 0; b--) shift_bit(VEC[p][16+b]);
      store_pulse();
      chk("R1 first word", {8'h0, d1}, {8'h0, VEC[p][15:8]});
      chk("R8 cascaded word", {8'h0, d2}, {8'h0, VEC[p][7:0]});
      chk("R8 ser_out top bit", {15'h0, so1}, {15'h0, r1[7]});
    end

    // R5: shifts invisible until store
    shift_bit(1); shift_bit(0); shift_bit(1);
    chk("R5 latch unchanged by shifts", {d2, d1}, {m2, m1});

    // R2: falling edge only, single shift
    si = 1'b1; sclk = 1'b1; cyc(4);
    si = 1'b0; sclk = 1'b0; cyc(4);
    r2 = {r2[6:0], r1[7]}; r1 = {r1[6:0], 1'b1};
    store_pulse();
    chk("R2 falling edge no shift", {d2, d1}, {r2, r1});

    // R6: shift and store in the same cycle
    pre = r1;
    si = ~r1[0]; sclk = 1'b1; rclk = 1'b1; cyc(4);
    sclk = 1'b0; rclk = 1'b0; cyc(4);
    r2 = {r2[6:0], r1[7]}; r1 = {r1[6:0], ~pre[0]};
    chk("R6 latch gets pre-shift word", {8'h0, d1}, {8'h0, pre});
    store_pulse();
    chk("R6 shift still applied", {8'h0, d1}, {8'h0, r1});

    // R7 / R10: output enable
    oe_n = 1'b1; cyc(1);
    chk("R10 oe after one edge", {8'h0, e1}, 16'h00FF);
    cyc(1);
    chk("R7 disabled enables", {e1, e2}, 16'h0);
    chk("R7 disabled data", {d1, d2}, 16'h0);
    oe_n = 1'b0; cyc(2);
    chk("R7 enabled", {e1, d1}, {8'hFF, m1});

    // R3: clear overrides shift; R5: latch kept
    shift_bit(1);
    clr_n = 1'b0; si = 1'b1; sclk = 1'b1; cyc(4);
    sclk = 1'b0; cyc(4);
    chk("R3 ser_out zero in clear", {15'h0, so1}, 16'h0);
    chk("R5 latch kept through clear", {d2, d1}, {m2, m1});
    clr_n = 1'b1; cyc(4);
    r1 = '0; r2 = '0;
    store_pulse();
    chk("R3 cleared word", {d2, d1}, 16'h0);

    // R4: falling store edge captures nothing
    shift_bit(1);
    rclk = 1'b1; cyc(4);
    chk("R4 rising store", {8'h0, d1}, 16'h0001);
    shift_bit(1);
    rclk = 1'b0; cyc(4);
    chk("R4 falling store ignored", {8'h0, d1}, 16'h0001);

    done = 1;
    summary();
    $finish;
  end
endmodule